// File: doc/BRIEF.md
# Byte-Oriented I2C Master Transmitter

This block is the transmit half of an I2C bus master. A host drives it with single-cycle command strobes and byte writes. It asks for a start condition, writes the address byte or bytes, writes the payload bytes, and asks for a stop condition. The block pulls SCL and SDA low through open-drain enables and samples the slave's acknowledge bit. It tells the host where it stands through single-cycle interrupt pulses, and each pulse is also held in a sticky status bit.

Each frame takes four phases of a programmable quarter-bit divider per bit. It shifts out eight bits, most significant first. It then releases SDA for a ninth clock and reads the acknowledge. A mode input selects how frame completion is reported. In one mode a single transmit request fires once the ACK slot has finished. In the other mode separate ACK and NACK requests fire, so a transfer engine can be paced on ACK and error handling can be started on NACK. Finishing a start or stop condition raises its own request. A byte written while a frame is running waits in a one-deep holding register and goes out directly after the current ACK slot.

Top module: `i2cMasterTx`

## Requirements
- R1: After reset both line enables are 0 (lines released), all four interrupt outputs are 0, and all sticky status bits and `nackFlag` are 0.
- R2: A `cmdStart` pulse while the bus is idle produces exactly one start condition: SDA falls while SCL is high. When it is done, `condIrq` pulses for one cycle. A `cmdStart` while the bus is not idle produces no second start condition.
- R3: Each frame sends the written byte most significant bit first, one bit per SCL high period. SDA is released during the ninth (acknowledge) clock. SDA never changes while SCL is high except in a start or stop condition.
- R4: During frames every SCL high period lasts 2*QUARTER clock cycles. Successive SCL rising edges inside a frame are 4*QUARTER cycles apart.
- R5: `nackFlag` holds the SDA level sampled in the most recent acknowledge slot: 0 for ACK, 1 for NACK.
- R6: With `intMode`=1, `txIrq` pulses once per completed frame, after its acknowledge slot. `ackIrq` and `nackIrq` stay 0.
- R7: With `intMode`=0, a frame that received ACK pulses `ackIrq` and a frame that received NACK pulses `nackIrq`. `txIrq` stays 0. At most one of the three frame requests is high in any cycle.
- R8: A byte written while the holding register is empty is sent after the frame in progress. Its first SCL rise comes 4*QUARTER cycles after the previous ACK rise, with no idle gap. A write while the holding register is full is ignored and never appears on the bus.
- R9: A `cmdStop` while the bus is owned produces a stop condition once the current frame ends and no byte is waiting: SDA rises while SCL is high. `condIrq` then pulses and the lines are released. A `cmdStop` while idle has no effect on the bus or on `condIrq`.
- R10: Bytes are sent in the order they were accepted. The first frame after a start is therefore the address byte: 7-bit address in bits 7:1 and bit 0 = 0 for write. For 10-bit addressing, the two address frames (11110 + address bits 9:8 + 0, then address bits 7:0) both go out before any data frame.
- R11: Each interrupt pulse sets its sticky status bit (`txPend`, `ackPend`, `nackPend`, `condPend`) in the next cycle. A `clrStatus` pulse clears all four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | Request a start condition (idle bus only) |
| cmdStop | input | 1 | Request a stop condition |
| dataWr | input | 1 | Byte write strobe |
| dataIn | input | 8 | Byte to transmit (address or data) |
| intMode | input | 1 | 1: frame-done request; 0: ACK/NACK requests |
| clrStatus | input | 1 | Clear all sticky status bits |
| sdaIn | input | 1 | Sensed SDA line level |
| sclOe | output | 1 | 1 pulls SCL low, 0 releases it |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |
| txIrq | output | 1 | Frame-complete pulse (intMode=1) |
| ackIrq | output | 1 | ACK-received pulse (intMode=0) |
| nackIrq | output | 1 | NACK-received pulse (intMode=0) |
| condIrq | output | 1 | Start or stop condition finished |
| txPend | output | 1 | Sticky copy of txIrq |
| ackPend | output | 1 | Sticky copy of ackIrq |
| nackPend | output | 1 | Sticky copy of nackIrq |
| condPend | output | 1 | Sticky copy of condIrq |
| nackFlag | output | 1 | Last sampled acknowledge level |

## Verification
The assertions assume that no other device pulls SCL low and that the slave changes SDA only while SCL is low. They also assume `sdaIn` is the wired-AND of the block's own enable and the slave's drive. The bench wires the line exactly that way. Its behavioural slave pulls SDA only from the SCL fall after the eighth bit to the fall after the ninth. The host writes a byte only after the interrupt that reports the previous frame, except for the deliberate over-write in the holding-register test. It changes `intMode` only while the bus is idle.

// File: rtl/i2cMtxPkg.sv
package i2cMtxPkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_HOLD,
    ST_XFER,
    ST_STOP
  } busStateT;

  // control -> datapath strobes
  typedef struct packed {
    logic runTimer;
    logic loadShift;
    logic shiftBit;
    logic sampleAck;
  } dpStrobeT;
endpackage

// File: rtl/i2cMtxDatapath.sv
module i2cMtxDatapath
  import i2cMtxPkg::*;
#(
  parameter int QUARTER = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          strobe,
  input  logic              dataWr,
  input  logic [BYTE_W-1:0] dataIn,
  input  logic              sdaIn,
  output logic              qEnd,
  output logic [1:0]        quarter,
  output logic [CNT_W-1:0]  bitCnt,
  output logic              txBit,
  output logic              bufValid,
  output logic              sdaNow,
  output logic              nackFlag
);
  localparam int DIV_W = (QUARTER > 1) ? $clog2(QUARTER) : 1;

  logic [DIV_W-1:0]  divCnt;
  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] bufData;
  logic              sdaMeta;
  logic              sdaSync;

  assign qEnd   = strobe.runTimer && (divCnt == DIV_W'(QUARTER - 1));
  assign txBit  = shiftReg[BYTE_W-1];
  assign sdaNow = sdaSync;

  // two-flop synchronizer on the sensed data line
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdaMeta <= 1'b1;
      sdaSync <= 1'b1;
    end else begin
      sdaMeta <= sdaIn;
      sdaSync <= sdaMeta;
    end
  end

  // quarter-bit timer
  always_ff @(posedge clk) begin
    if (!rstN || !strobe.runTimer) begin
      divCnt  <= '0;
      quarter <= '0;
    end else if (qEnd) begin
      divCnt  <= '0;
      quarter <= quarter + 2'd1;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  // shifter and bit counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (strobe.loadShift) begin
      shiftReg <= bufData;
      bitCnt   <= '0;
    end else if (strobe.shiftBit) begin
      shiftReg <= {shiftReg[BYTE_W-2:0], 1'b0};
      bitCnt   <= bitCnt + CNT_W'(1);
    end
  end

  // one-deep holding register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufValid <= 1'b0;
      bufData  <= '0;
    end else if (strobe.loadShift) begin
      bufValid <= 1'b0;
    end else if (dataWr && !bufValid) begin
      bufValid <= 1'b1;
      bufData  <= dataIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 nackFlag <= 1'b0;
    else if (strobe.sampleAck) nackFlag <= sdaSync;
  end

  // R8: a write into a full holding register leaves its content alone
  a_r8_full_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (bufValid && dataWr && !strobe.loadShift) |=> (bufData == $past(bufData)));

  // R3: the counter never runs past the acknowledge slot
  a_r3_bit_range: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(BYTE_W));
endmodule

// File: rtl/i2cMtxControl.sv
module i2cMtxControl
  import i2cMtxPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdStart,
  input  logic             cmdStop,
  input  logic             intMode,
  input  logic             clrStatus,
  input  logic             qEnd,
  input  logic [1:0]       quarter,
  input  logic [CNT_W-1:0] bitCnt,
  input  logic             txBit,
  input  logic             bufValid,
  input  logic             sdaNow,
  output dpStrobeT         strobe,
  output logic             sclOe,
  output logic             sdaOe,
  output logic             txIrq,
  output logic             ackIrq,
  output logic             nackIrq,
  output logic             condIrq,
  output logic             txPend,
  output logic             ackPend,
  output logic             nackPend,
  output logic             condPend
);
  busStateT state, stateNext;
  logic stopPend, frameDone, condDone;
  logic sclNext, sdaNext, condPhase;
  logic bitEnd, lastBit;

  assign bitEnd  = qEnd && (quarter == 2'd3);
  assign lastBit = (bitCnt == CNT_W'(BYTE_W));

  always_comb begin
    stateNext       = state;
    strobe          = '0;
    strobe.runTimer = (state == ST_START) || (state == ST_XFER) || (state == ST_STOP);
    frameDone       = 1'b0;
    condDone        = 1'b0;
    unique case (state)
      ST_IDLE:  if (cmdStart) stateNext = ST_START;
      ST_START: if (bitEnd) begin
        stateNext = ST_HOLD;
        condDone  = 1'b1;
      end
      ST_HOLD: begin
        if (bufValid) begin
          strobe.loadShift = 1'b1;
          stateNext        = ST_XFER;
        end else if (stopPend) begin
          stateNext = ST_STOP;
        end
      end
      ST_XFER: if (bitEnd) begin
        if (!lastBit) begin
          strobe.shiftBit = 1'b1;
        end else begin
          strobe.sampleAck = 1'b1;
          frameDone        = 1'b1;
          if (bufValid) strobe.loadShift = 1'b1;
          else if (stopPend) stateNext = ST_STOP;
          else stateNext = ST_HOLD;
        end
      end
      ST_STOP: if (bitEnd) begin
        stateNext = ST_IDLE;
        condDone  = 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // line drive: 1 = pull low
  always_comb begin
    sclNext   = 1'b0;
    sdaNext   = 1'b0;
    condPhase = ((state == ST_START) || (state == ST_STOP)) && quarter[1];
    unique case (state)
      ST_START: sdaNext = quarter[1];
      ST_HOLD: begin
        sclNext = 1'b1;
        sdaNext = 1'b1;
      end
      ST_XFER: begin
        sclNext = !quarter[1];
        sdaNext = lastBit ? 1'b0 : !txBit;
      end
      ST_STOP: begin
        sclNext = !quarter[1];
        sdaNext = (quarter != 2'd3);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      stopPend <= 1'b0;
      sclOe    <= 1'b0;
      sdaOe    <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_STOP)                   stopPend <= 1'b0;
      else if (cmdStop && state != ST_IDLE)   stopPend <= 1'b1;
      sclOe <= sclNext;
      // data moves only under a low clock, or inside a condition phase
      if (sclOe || condPhase) sdaOe <= sdaNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {txIrq, ackIrq, nackIrq, condIrq}     <= '0;
      {txPend, ackPend, nackPend, condPend} <= '0;
    end else begin
      txIrq    <= frameDone && intMode;
      ackIrq   <= frameDone && !intMode && !sdaNow;
      nackIrq  <= frameDone && !intMode && sdaNow;
      condIrq  <= condDone;
      txPend   <= (txPend   && !clrStatus) || txIrq;
      ackPend  <= (ackPend  && !clrStatus) || ackIrq;
      nackPend <= (nackPend && !clrStatus) || nackIrq;
      condPend <= (condPend && !clrStatus) || condIrq;
    end
  end

  a_r3_sda_moves_under_low_clock: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaOe) && !$past(sclOe)) |->
      ($past(state) == ST_START || $past(state) == ST_STOP));

  a_r7_frame_irq_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({txIrq, ackIrq, nackIrq}));

  a_r11_tx_sticky: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |=> txPend);

  a_r11_cond_sticky: assert property (@(posedge clk) disable iff (!rstN)
    condIrq |=> condPend);

  a_r11_clear: assert property (@(posedge clk) disable iff (!rstN)
    (clrStatus && !ackIrq && !nackIrq) |=> (!ackPend && !nackPend));
endmodule

// File: rtl/i2cMasterTx.sv
module i2cMasterTx
  import i2cMtxPkg::*;
#(
  parameter int QUARTER = 25
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdStart,
  input  logic       cmdStop,
  input  logic       dataWr,
  input  logic [7:0] dataIn,
  input  logic       intMode,
  input  logic       clrStatus,
  input  logic       sdaIn,
  output logic       sclOe,
  output logic       sdaOe,
  output logic       txIrq,
  output logic       ackIrq,
  output logic       nackIrq,
  output logic       condIrq,
  output logic       txPend,
  output logic       ackPend,
  output logic       nackPend,
  output logic       condPend,
  output logic       nackFlag
);
  dpStrobeT         strobe;
  logic             qEnd, txBit, bufValid, sdaNow;
  logic [1:0]       quarter;
  logic [CNT_W-1:0] bitCnt;

  i2cMtxControl u_ctrl (
    .clk, .rstN, .cmdStart, .cmdStop, .intMode, .clrStatus,
    .qEnd, .quarter, .bitCnt, .txBit, .bufValid, .sdaNow,
    .strobe, .sclOe, .sdaOe, .txIrq, .ackIrq, .nackIrq, .condIrq,
    .txPend, .ackPend, .nackPend, .condPend
  );

  i2cMtxDatapath #(.QUARTER(QUARTER)) u_dp (
    .clk, .rstN, .strobe, .dataWr, .dataIn, .sdaIn,
    .qEnd, .quarter, .bitCnt, .txBit, .bufValid, .sdaNow, .nackFlag
  );

  // R5/R7: the request kind agrees with the latched acknowledge level
  a_r5_ack_irq_flag: assert property (@(posedge clk) disable iff (!rstN)
    ackIrq |-> !nackFlag);
  a_r5_nack_irq_flag: assert property (@(posedge clk) disable iff (!rstN)
    nackIrq |-> nackFlag);
endmodule

// File: tb/i2cMasterTx_tb.sv
module i2cMasterTx_tb;
  localparam int Q = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdStart = 0, cmdStop = 0, dataWr = 0, intMode = 1, clrStatus = 0;
  logic [7:0] dataIn = 0;
  logic sdaIn, sclOe, sdaOe, txIrq, ackIrq, nackIrq, condIrq;
  logic txPend, ackPend, nackPend, condPend, nackFlag;
  logic slaveLow = 1'b0;

  always #4 clk = ~clk;
  assign sdaIn = !(sdaOe || slaveLow);

  i2cMasterTx #(.QUARTER(Q)) u_dut (
    .clk, .rstN, .cmdStart, .cmdStop, .dataWr, .dataIn, .intMode, .clrStatus,
    .sdaIn, .sclOe, .sdaOe, .txIrq, .ackIrq, .nackIrq, .condIrq,
    .txPend, .ackPend, .nackPend, .condPend, .nackFlag
  );

  int total = 0, bad = 0;
  bit done = 0;
  int cyc = 0, startCnt = 0, stopCnt = 0, rxCnt = 0, expCnt = 0;
  int txCnt = 0, ackCnt = 0, nackCnt = 0, condCnt = 0;
  int tightBad = 0, highBad = 0, nackAt = -1;
  int bitIdx = 0, prevRise = 0, highStart = 0;
  bit haveRise = 0, risen = 0, prevScl = 1, prevSda = 1;
  logic [7:0] shiftIn = 0;
  logic [7:0] rxLog [0:511];
  logic [7:0] expLog [0:511];
  int gapLog [0:511];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bus monitor and behavioural slave
  always @(negedge clk) begin
    bit scl, sda;
    cyc++;
    scl = !sclOe;
    sda = sdaIn;
    if (rstN) begin
      if (txIrq) txCnt++;
      if (ackIrq) ackCnt++;
      if (nackIrq) nackCnt++;
      if (condIrq) condCnt++;
      if (scl && prevScl && prevSda && !sda) begin
        startCnt++; bitIdx = 0; haveRise = 0; risen = 0; slaveLow = 0;
      end else if (scl && prevScl && !prevSda && sda) begin
        stopCnt++;
      end
      if (scl && !prevScl) begin
        if (bitIdx < 8) shiftIn = {shiftIn[6:0], sda};
        if (bitIdx == 0) begin
          if (rxCnt < 512) gapLog[rxCnt] = haveRise ? cyc - prevRise : 0;
        end else if (bitIdx <= 8 && cyc - prevRise != 4*Q) tightBad++;
        bitIdx++;
        if (bitIdx == 8 && rxCnt < 512) begin
          rxLog[rxCnt] = shiftIn;
          rxCnt++;
        end
        prevRise = cyc; haveRise = 1; highStart = cyc; risen = 1;
      end
      if (!scl && prevScl) begin
        if (risen && cyc - highStart != 2*Q) highBad++;
        risen = 0;
        if (bitIdx == 8) slaveLow = (rxCnt - 1 != nackAt);
        else if (bitIdx == 9) begin slaveLow = 0; bitIdx = 0; end
      end
    end
    prevScl = scl;
    prevSda = sda;
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask
  task automatic pulseStart();
    @(negedge clk) cmdStart = 1; @(negedge clk) cmdStart = 0;
  endtask
  task automatic pulseStop();
    @(negedge clk) cmdStop = 1; @(negedge clk) cmdStop = 0;
  endtask
  task automatic pulseClr();
    @(negedge clk) clrStatus = 1; @(negedge clk) clrStatus = 0;
  endtask
  task automatic writeByte(input logic [7:0] b, input bit accepted);
    @(negedge clk) begin dataWr = 1; dataIn = b; end
    @(negedge clk) dataWr = 0;
    if (accepted) begin expLog[expCnt] = b; expCnt++; end
  endtask
  task automatic waitCond(input int n);
    while (condCnt < n) @(negedge clk);
  endtask
  task automatic compareLog(input int from, input string req);
    check(rxCnt == expCnt, {req, " frame count"}, rxCnt, expCnt);
    for (int i = from; i < expCnt; i++)
      check(rxLog[i] == expLog[i], {req, " byte MSB-first order"}, rxLog[i], expLog[i]);
  endtask

  initial begin
    int nWr, base, gb;
    tick(5);
    // R1: reset state
    check(sclOe == 0 && sdaOe == 0, "R1 lines released", {sclOe, sdaOe}, 0);
    check({txIrq, ackIrq, nackIrq, condIrq} == 0, "R1 irqs low", {txIrq, ackIrq, nackIrq, condIrq}, 0);
    check({txPend, ackPend, nackPend, condPend, nackFlag} == 0, "R1 status clear",
          {txPend, ackPend, nackPend, condPend, nackFlag}, 0);
    rstN = 1;
    tick(5);

    // Transaction A: frame mode, 7-bit address, payload 0..127
    intMode = 1;
    pulseStart();
    waitCond(1);
    check(startCnt == 1, "R2 start condition", startCnt, 1);
    tick(1);
    check(condPend == 1, "R11 condPend set", condPend, 1);
    base = 0;
    writeByte(8'hA4, 1);
    tick(3);
    nWr = 1;
    for (int i = 0; i < 128; i++) begin
      writeByte(i[7:0], 1);
      nWr++;
      if (i == 40) pulseStart(); // R2: ignored while busy
      while (txCnt < nWr - 1) @(negedge clk);
    end
    pulseStop();
    waitCond(2);
    tick(4);
    check(startCnt == 1, "R2 start ignored while busy", startCnt, 1);
    check(stopCnt == 1, "R9 stop condition", stopCnt, 1);
    check(sclOe == 0 && sdaOe == 0, "R9 lines released after stop", {sclOe, sdaOe}, 0);
    check(rxLog[base] == 8'hA4, "R10 7-bit address first", rxLog[base], 8'hA4);
    compareLog(base, "R3");
    check(txCnt == nWr, "R6 txIrq per frame", txCnt, nWr);
    check(ackCnt + nackCnt == 0, "R6 no ack/nack irq in frame mode", ackCnt + nackCnt, 0);
    check(nackFlag == 0, "R5 ACK reads 0", nackFlag, 0);
    check(tightBad == 0, "R4 bit spacing", tightBad, 0);
    check(highBad == 0, "R4 SCL high width", highBad, 0);
    gb = 0;
    for (int i = base + 1; i < expCnt; i++) if (gapLog[i] != 4*Q) gb++;
    check(gb == 0, "R8 back-to-back frames", gb, 0);
    check(txPend == 1, "R11 txPend set", txPend, 1);
    pulseClr();
    tick(1);
    check({txPend, ackPend, nackPend, condPend} == 0, "R11 cleared",
          {txPend, ackPend, nackPend, condPend}, 0);

    // Transaction B: ACK/NACK mode, 10-bit address, payload 128..255, last NACKed
    intMode = 0;
    base = expCnt;
    nackAt = base + 2 + 127;
    pulseStart();
    waitCond(3);
    writeByte(8'hF6, 1);
    tick(3);
    nWr = 1;
    writeByte(8'h3C, 1);
    nWr++;
    while (ackCnt < nWr - 1) @(negedge clk);
    for (int i = 128; i < 256; i++) begin
      writeByte(i[7:0], 1);
      nWr++;
      if (i < 255) while (ackCnt < nWr - 1) @(negedge clk);
    end
    while (nackCnt < 1) @(negedge clk);
    tick(1);
    check(nackFlag == 1, "R5 NACK reads 1", nackFlag, 1);
    check(nackPend == 1, "R11 nackPend set", nackPend, 1);
    pulseStop();
    waitCond(4);
    tick(4);
    check(rxLog[base] == 8'hF6 && rxLog[base+1] == 8'h3C, "R10 10-bit address frames first",
          rxLog[base], 8'hF6);
    compareLog(base, "R3");
    check(ackCnt == nWr - 1, "R7 ackIrq count", ackCnt, nWr - 1);
    check(nackCnt == 1, "R7 nackIrq count", nackCnt, 1);
    check(txCnt == 129, "R7 no txIrq in ack mode", txCnt, 129);
    check(stopCnt == 2, "R9 stop after NACK", stopCnt, 2);
    check(tightBad == 0 && highBad == 0, "R4 timing in ack mode", tightBad + highBad, 0);

    // Transaction C: holding register full, extra write dropped
    intMode = 1;
    nackAt = -1;
    base = expCnt;
    pulseStart();
    waitCond(5);
    writeByte(8'h5A, 1);
    writeByte(8'hC3, 1);
    writeByte(8'h99, 0);
    pulseStop();
    waitCond(6);
    tick(4);
    compareLog(base, "R8");
    check(gapLog[base+1] == 4*Q, "R8 buffered byte without gap", gapLog[base+1], 4*Q);
    check(startCnt == 3 && stopCnt == 3, "R2 condition count", startCnt * 10 + stopCnt, 33);

    // R9: stop while idle has no effect
    pulseStop();
    tick(60);
    check(stopCnt == 3, "R9 idle stop ignored (bus)", stopCnt, 3);
    check(condCnt == 6, "R9 idle stop ignored (condIrq)", condCnt, 6);
    check(sclOe == 0 && sdaOe == 0, "R9 idle lines", {sclOe, sdaOe}, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule